// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Decoder

This block turns a pair of squared tone signals into a keypad digit. One input carries the low-frequency group and the other carries the high-frequency group. Zero-crossing comparators outside the block have already squared both signals. Each input passes through a synchronizer and an edge detector. The block then counts system-clock cycles between rising edges and sums four consecutive periods. It compares that sum against accept and reject windows built at elaboration time for each of the four tones in the group.

Each group keeps one match flag per tone. A sum inside the narrow accept window sets the flag. A sum outside the wide reject window clears it. A sum between the two windows leaves the flag unchanged. A group that shows no rising edge for a timeout period has all of its flags cleared.

When exactly one tone matches in each group, the block registers a 4-bit code for that key and raises a valid flag. An inhibit input suppresses every key in the highest column. Output latching and duration qualification are left to a steering stage further downstream.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: A 4-period sum whose frequency is within 1.5% of a nominal tone sets that tone's match. The low-group tones are 697, 770, 852 and 941 Hz. The high-group tones are 1209, 1336, 1477 and 1633 Hz. All periods are counted in cycles of a clock of `CLK_HZ` (default 3,579,545).
- R2: A 4-period sum whose frequency is 3.5% or more away from a tone clears that tone's match.
- R3: A sum that falls between the accept window and the reject window leaves that tone's match as it was. A tone with no prior match therefore stays unmatched.
- R4: `tone_valid_o` is 1 only when exactly one low tone and exactly one high tone match. Rows are the low tones in ascending order. Columns are the high tones in ascending order.
- R5: `digit_o` encodes the key as follows: keys 1..9 are 0001..1001, key 0 is 1010, * is 1011, # is 1100, A is 1101, B is 1110, C is 1111 and D is 0000. The key layout is: row 1 is 1 2 3 A, row 2 is 4 5 6 B, row 3 is 7 8 9 C, row 4 is * 0 # D.
- R6: While `inhibit_i` is 1, no key in the 1633 Hz column (A, B, C, D) is reported valid. Keys in the other three columns are not affected. `inhibit_i` is to be tied low when unused.
- R7: A group is silent once it has shown no rising edge for `TMO_MULT` (default 2) times the period of its lowest tone taken 3.5% low. A silent group has all of its matches cleared, and `tone_valid_o` falls. A gap shorter than this leaves the output unchanged.
- R8: After reset, `tone_valid_o` is 0 and `digit_o` is 0000.
- R9: While `tone_valid_o` is 0, `digit_o` is 0000.
- R10: A change of `inhibit_i` reaches the outputs at the first rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally `CLK_HZ` |
| rst_n | input | 1 | Asynchronous reset, active low |
| low_sq_i | input | 1 | Squared low-group tone |
| high_sq_i | input | 1 | Squared high-group tone |
| inhibit_i | input | 1 | Suppresses keys in the 1633 Hz column |
| digit_o | output | 4 | Key code, 0000 while not valid |
| tone_valid_o | output | 1 | Exactly one tone matched in each group |

## Verification
The key code and valid flag follow the rising edge that closes a four-period window by five clock edges. Two of those edges are the synchronizer; the others are the period sample, the match register and the output register. Because the first window after a tone change can mix the old and new tones, each tone scenario is sampled only after twelve periods of the slowest low tone. By then at least two clean windows have been classified.

An `inhibit_i` change is due one edge later, so it is checked on the very next falling edge. The silence checks are placed on either side of the timeout: one well before the earliest moment a group can time out, and one well after the latest.

// File: rtl/dtmf_pkg.sv
`timescale 1ns/1ps
package dtmf_pkg;

   localparam int unsigned N_TONES = 4;

   typedef enum logic {GRP_LOW = 1'b0, GRP_HIGH = 1'b1} grp_e;
   typedef logic [N_TONES-1:0] tone_vec_t;

   // nominal tone frequency, ascending inside each group
   function automatic longint unsigned tone_hz(input grp_e grp, input int idx);
      if (grp == GRP_LOW) begin
         case (idx)
            0:       return 697;
            1:       return 770;
            2:       return 852;
            default: return 941;
         endcase
      end else begin
         case (idx)
            0:       return 1209;
            1:       return 1336;
            2:       return 1477;
            default: return 1633;
         endcase
      end
   endfunction

   // clock cycles in AVG periods of a tone scaled by 1000/den
   function automatic longint unsigned sum_bound(input longint unsigned clk_hz,
                                                 input longint unsigned avg,
                                                 input longint unsigned hz,
                                                 input longint unsigned den);
      return (clk_hz * avg * 1000) / (hz * den);
   endfunction

   // key code from row (low tone index) and column (high tone index)
   function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
      if (col == 2'd3) begin
         if (row == 2'd3) return 4'd0;
         return 4'(13 + int'(row));
      end
      if (row == 2'd3) begin
         case (col)
            2'd0:    return 4'd11;
            2'd1:    return 4'd10;
            default: return 4'd12;
         endcase
      end
      return 4'(int'(row) * 3 + int'(col) + 1);
   endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
`timescale 1ns/1ps
module dtmf_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sq_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dtmf_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], sq_i};
   end

   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/dtmf_period_meter.sv
`timescale 1ns/1ps
module dtmf_period_meter #(
   parameter int              CNT_W    = 14,
   parameter int              AVG_LOG2 = 2,
   parameter longint unsigned TMO_CYC  = 10644,
   localparam int             SUM_W    = CNT_W + AVG_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   output logic             sum_vld_o,
   output logic [SUM_W-1:0] sum_o,
   output logic             silent_o
);

   if (TMO_CYC >= (64'd1 << CNT_W)) begin : g_bad_width
      $error("dtmf_period_meter: CNT_W too narrow for TMO_CYC");
   end
   if (AVG_LOG2 < 0 || AVG_LOG2 > 4) begin : g_bad_avg
      $error("dtmf_period_meter: AVG_LOG2 out of range 0..4");
   end

   localparam logic [CNT_W-1:0] TMO = CNT_W'(TMO_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             silent_q;
   logic             timeout;
   logic             per_vld;
   logic             vld_q;
   logic [SUM_W-1:0] sum_q;

   assign timeout = (cnt_q >= TMO);
   assign per_vld = rise_i & armed_q;

   // cycles since the last rising edge, saturating at the timeout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         silent_q <= 1'b1;
      end else if (rise_i) begin
         cnt_q    <= CNT_W'(1);
         armed_q  <= 1'b1;
         silent_q <= 1'b0;
      end else if (timeout) begin
         armed_q  <= 1'b0;
         silent_q <= 1'b1;
      end else begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   if (AVG_LOG2 == 0) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            sum_q <= '0;
         end else begin
            vld_q <= per_vld;
            if (per_vld) sum_q <= cnt_q;
         end
      end
   end else begin : g_avg
      logic [AVG_LOG2-1:0] idx_q;
      logic [SUM_W-1:0]    acc_q;
      logic [SUM_W-1:0]    acc_nxt;

      assign acc_nxt = acc_q + SUM_W'(cnt_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q <= '0;
            acc_q <= '0;
            vld_q <= 1'b0;
            sum_q <= '0;
         end else begin
            vld_q <= 1'b0;
            if (timeout && !rise_i) begin
               idx_q <= '0;
               acc_q <= '0;
            end else if (per_vld) begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == '1) begin
                  sum_q <= acc_nxt;
                  vld_q <= 1'b1;
                  acc_q <= '0;
               end else begin
                  acc_q <= acc_nxt;
               end
            end
         end
      end
   end

   assign sum_vld_o = vld_q;
   assign sum_o     = sum_q;
   assign silent_o  = silent_q;

   p_cnt_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TMO);

   p_sum_after_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sum_vld_o |-> $past(rise_i));

endmodule

// File: rtl/dtmf_tone_classifier.sv
`timescale 1ns/1ps
module dtmf_tone_classifier
   import dtmf_pkg::*;
#(
   parameter grp_e            GROUP      = GRP_LOW,
   parameter longint unsigned CLK_HZ     = 3579545,
   parameter int              AVG_LOG2   = 2,
   parameter int              ACC_PERMIL = 15,
   parameter int              REJ_PERMIL = 35,
   parameter int              SUM_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sum_vld_i,
   input  logic [SUM_W-1:0] sum_i,
   input  logic             silent_i,
   output tone_vec_t        match_o
);

   localparam longint unsigned AVG = 64'd1 << AVG_LOG2;

   if (ACC_PERMIL <= 0 || ACC_PERMIL >= REJ_PERMIL || REJ_PERMIL >= 500) begin : g_bad_band
      $error("dtmf_tone_classifier: need 0 < ACC_PERMIL < REJ_PERMIL < 500");
   end

   for (genvar t = 0; t < N_TONES; t++) begin : g_tone
      localparam longint unsigned HZ     = tone_hz(GROUP, t);
      localparam longint unsigned ACC_LO = sum_bound(CLK_HZ, AVG, HZ, 1000 + ACC_PERMIL);
      localparam longint unsigned ACC_HI = sum_bound(CLK_HZ, AVG, HZ, 1000 - ACC_PERMIL);
      localparam longint unsigned REJ_LO = sum_bound(CLK_HZ, AVG, HZ, 1000 + REJ_PERMIL);
      localparam longint unsigned REJ_HI = sum_bound(CLK_HZ, AVG, HZ, 1000 - REJ_PERMIL);

      if (t < N_TONES - 1) begin : g_gap
         localparam longint unsigned NXT_ACC_HI =
            sum_bound(CLK_HZ, AVG, tone_hz(GROUP, t + 1), 1000 - ACC_PERMIL);
         if (NXT_ACC_HI >= REJ_LO) begin : g_overlap
            $error("dtmf_tone_classifier: neighbouring tone windows overlap");
         end
      end
      if (REJ_HI >= (64'd1 << SUM_W)) begin : g_bad_sum
         $error("dtmf_tone_classifier: SUM_W too narrow");
      end

      logic sum_in_acc;
      logic sum_out_rej;
      logic hit_q;

      assign sum_in_acc  = (64'(sum_i) >= ACC_LO) && (64'(sum_i) <= ACC_HI);
      assign sum_out_rej = (64'(sum_i) <  REJ_LO) || (64'(sum_i) >  REJ_HI);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      hit_q <= 1'b0;
         else if (silent_i)               hit_q <= 1'b0;
         else if (sum_vld_i) begin
            if (sum_in_acc)               hit_q <= 1'b1;
            else if (sum_out_rej)         hit_q <= 1'b0;
         end
      end

      assign match_o[t] = hit_q;
   end

   p_one_tone_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_o));

   p_silence_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      silent_i |=> (match_o == '0));

endmodule

// File: rtl/dtmf_pair_decoder.sv
`timescale 1ns/1ps
module dtmf_pair_decoder
   import dtmf_pkg::*;
#(
   parameter longint unsigned CLK_HZ      = 3579545,
   parameter int              AVG_LOG2    = 2,
   parameter int              ACC_PERMIL  = 15,
   parameter int              REJ_PERMIL  = 35,
   parameter int              SYNC_STAGES = 2,
   parameter int              TMO_MULT    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       low_sq_i,
   input  logic       high_sq_i,
   input  logic       inhibit_i,
   output logic [3:0] digit_o,
   output logic       tone_valid_o
);

   if (TMO_MULT < 2) begin : g_bad_tmo
      $error("dtmf_pair_decoder: TMO_MULT must be at least 2");
   end
   if (CLK_HZ < 64'd20000) begin : g_bad_clk
      $error("dtmf_pair_decoder: CLK_HZ too low to resolve the tones");
   end

   tone_vec_t grp_match [2];

   for (genvar g = 0; g < 2; g++) begin : g_grp
      localparam grp_e            GRP   = grp_e'(g);
      localparam longint unsigned TMO   = longint'(TMO_MULT) *
                                          sum_bound(CLK_HZ, 1, tone_hz(GRP, 0), 1000 - REJ_PERMIL);
      localparam int              CNT_W = $clog2(TMO + 1);
      localparam int              SUM_W = CNT_W + AVG_LOG2;

      logic             sq;
      logic             rise;
      logic             sum_vld;
      logic [SUM_W-1:0] sum;
      logic             silent;
      tone_vec_t        match;

      assign sq = (g == 0) ? low_sq_i : high_sq_i;

      dtmf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .sq_i   (sq),
         .rise_o (rise)
      );

      dtmf_period_meter #(
         .CNT_W    (CNT_W),
         .AVG_LOG2 (AVG_LOG2),
         .TMO_CYC  (TMO)
      ) u_meter (
         .clk       (clk),
         .rst_n     (rst_n),
         .rise_i    (rise),
         .sum_vld_o (sum_vld),
         .sum_o     (sum),
         .silent_o  (silent)
      );

      dtmf_tone_classifier #(
         .GROUP      (GRP),
         .CLK_HZ     (CLK_HZ),
         .AVG_LOG2   (AVG_LOG2),
         .ACC_PERMIL (ACC_PERMIL),
         .REJ_PERMIL (REJ_PERMIL),
         .SUM_W      (SUM_W)
      ) u_class (
         .clk       (clk),
         .rst_n     (rst_n),
         .sum_vld_i (sum_vld),
         .sum_i     (sum),
         .silent_i  (silent),
         .match_o   (match)
      );

      assign grp_match[g] = match;
   end

   tone_vec_t  lo_m;
   tone_vec_t  hi_m;
   logic [1:0] row;
   logic [1:0] col;
   logic       pair_ok;
   logic [3:0] digit_q;
   logic       valid_q;

   assign lo_m = grp_match[0];
   assign hi_m = grp_match[1];

   always_comb begin
      row = 2'd0;
      col = 2'd0;
      for (int i = 0; i < N_TONES; i++) begin
         if (lo_m[i]) row = 2'(i);
         if (hi_m[i]) col = 2'(i);
      end
      pair_ok = $onehot(lo_m) && $onehot(hi_m) && !(inhibit_i && hi_m[N_TONES-1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         digit_q <= 4'd0;
      end else begin
         valid_q <= pair_ok;
         digit_q <= pair_ok ? pair_code(row, col) : 4'd0;
      end
   end

   assign digit_o      = digit_q;
   assign tone_valid_o = valid_q;

   p_inhibit_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_valid_o && $past(inhibit_i)) |-> !(digit_o inside {4'd0, 4'd13, 4'd14, 4'd15}));

   p_valid_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tone_valid_o |-> (($past(lo_m) != '0) && ($past(hi_m) != '0)));

endmodule

// File: tb/sim_dtmf_pair_decoder.sv
`timescale 1ns/1ps
module sim_dtmf_pair_decoder;

   localparam int  CLK_HZ = 178977;   // scaled system clock for short runs
   localparam int  SETTLE = 3400;     // beyond 12 periods of the slowest low tone
   localparam real LO_HZ [4] = '{697.0, 770.0, 852.0, 941.0};
   localparam real HI_HZ [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
   localparam logic [3:0] KEY [4][4] = '{'{4'd1,  4'd2,  4'd3,  4'd13},
                                         '{4'd4,  4'd5,  4'd6,  4'd14},
                                         '{4'd7,  4'd8,  4'd9,  4'd15},
                                         '{4'd11, 4'd10, 4'd12, 4'd0}};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       low_sq = 1'b0;
   logic       high_sq = 1'b0;
   logic       inhibit = 1'b0;
   logic [3:0] digit;
   logic       valid;

   int n_chk = 0;
   int n_bad = 0;
   int lo_per = 0;
   int hi_per = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dtmf_pair_decoder #(.CLK_HZ(CLK_HZ)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .low_sq_i     (low_sq),
      .high_sq_i    (high_sq),
      .inhibit_i    (inhibit),
      .digit_o      (digit),
      .tone_valid_o (valid)
   );

   // square-wave sources, period in cycles, 0 means silent
   initial begin : gen_low
      int ph = 0;
      forever begin
         @(negedge clk);
         if (lo_per == 0) begin ph = 0; low_sq = 1'b0; end
         else begin
            ph = (ph + 1 >= lo_per) ? 0 : ph + 1;
            low_sq = (ph < lo_per / 2);
         end
      end
   end

   initial begin : gen_high
      int ph = 0;
      forever begin
         @(negedge clk);
         if (hi_per == 0) begin ph = 0; high_sq = 1'b0; end
         else begin
            ph = (ph + 1 >= hi_per) ? 0 : ph + 1;
            high_sq = (ph < hi_per / 2);
         end
      end
   end

   function automatic int per_of(real hz, real dev_pct);
      return $rtoi(real'(CLK_HZ) / (hz * (1.0 + dev_pct / 100.0)) + 0.5);
   endfunction

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic chk(string req, logic vld_exp, logic [3:0] dig_exp);
      n_chk++;
      if (valid !== vld_exp || digit !== dig_exp) begin
         n_bad++;
         $display("FAIL %s: valid=%b digit=%b, expected valid=%b digit=%b",
                  req, valid, digit, vld_exp, dig_exp);
      end
   endtask

   task automatic tones(real lo_hz, real lo_dev, real hi_hz, real hi_dev);
      lo_per = (lo_hz > 0.0) ? per_of(lo_hz, lo_dev) : 0;
      hi_per = (hi_hz > 0.0) ? per_of(hi_hz, hi_dev) : 0;
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (20) @(negedge clk);
      chk("R8 reset state", 1'b0, 4'd0);
   endtask

   task automatic t_all_keys();
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++) begin
            tones(LO_HZ[r], 0.0, HI_HZ[c], 0.0);
            chk($sformatf("R1 R4 R5 key row%0d col%0d", r, c), 1'b1, KEY[r][c]);
         end
   endtask

   task automatic t_inhibit();
      inhibit = 1'b1;
      tones(LO_HZ[1], 0.0, HI_HZ[3], 0.0);
      chk("R6 R9 B inhibited", 1'b0, 4'd0);
      inhibit = 1'b0;
      @(negedge clk);
      chk("R10 inhibit release", 1'b1, 4'd14);
      inhibit = 1'b1;
      @(negedge clk);
      chk("R10 inhibit apply", 1'b0, 4'd0);
      tones(LO_HZ[1], 0.0, HI_HZ[2], 0.0);
      chk("R6 key 6 unaffected", 1'b1, 4'd6);
      inhibit = 1'b0;
   endtask

   task automatic t_near_edge();
      tones(LO_HZ[2], -1.0, HI_HZ[2], 1.0);
      chk("R1 key 9 at 1% off", 1'b1, 4'd9);
   endtask

   task automatic t_hold_band();
      tones(LO_HZ[1], 0.0, HI_HZ[1], 0.0);
      chk("R1 key 5 nominal", 1'b1, 4'd5);
      tones(LO_HZ[1], 2.5, HI_HZ[1], 0.0);
      chk("R3 key 5 held at 2.5%", 1'b1, 4'd5);
      tones(0.0, 0.0, 0.0, 0.0);
      chk("R7 R9 both silent", 1'b0, 4'd0);
      tones(LO_HZ[1], 2.5, HI_HZ[1], 0.0);
      chk("R3 no prior match at 2.5%", 1'b0, 4'd0);
   endtask

   task automatic t_reject();
      tones(LO_HZ[1], 0.0, HI_HZ[1], 0.0);
      tones(LO_HZ[1], 5.0, HI_HZ[1], 0.0);
      chk("R2 low tone 5% high", 1'b0, 4'd0);
      tones(LO_HZ[1], 0.0, HI_HZ[1], 0.0);
      chk("R1 key 5 restored", 1'b1, 4'd5);
      tones(LO_HZ[1], 0.0, HI_HZ[1], -5.0);
      chk("R2 high tone 5% low", 1'b0, 4'd0);
   endtask

   task automatic t_silence();
      tones(LO_HZ[2], 0.0, HI_HZ[1], 0.0);
      chk("R1 key 8", 1'b1, 4'd8);
      hi_per = 0;
      repeat (100) @(negedge clk);
      chk("R7 short gap keeps key 8", 1'b1, 4'd8);
      repeat (500) @(negedge clk);
      chk("R7 R4 high silent drops valid", 1'b0, 4'd0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run incomplete, expected finish before limit");
         finish_run();
      end
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_all_keys();
      t_inhibit();
      t_near_edge();
      t_hold_band();
      t_reject();
      t_silence();
      done = 1'b1;
      finish_run();
   end

endmodule